// File: doc/BRIEF.md
# Length-Prefixed Transmit Frame Buffer

This block sits in front of an Ethernet MAC transmitter. Software loads a frame through a 32-bit data port, one word at a time. The first word written into an empty buffer carries the payload length in its low 16 bits. The buffer stores every word as four bytes and tracks how many bytes it holds. From that count it decides when the frame is complete. It then emits the header and payload as a byte stream with valid, ready and last.

A frame can start in two ways. The first is an automatic start after a data write. This needs a programmable fill threshold to be met and the stored bytes to cover the whole frame. The second is a forced start from a request pulse. Short frames can be zero-padded to 60 bytes. While a frame is being emitted, the block reports busy and refuses further words. A completed transmission raises an empty flag. A rejected length raises an error flag, and acknowledging that flag also discards the buffer contents.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset the buffer is empty, `busy`, `m_valid`, `tx_empty` and `tx_err` are low, and the threshold register holds 63.
- R2: An accepted word is stored as four bytes, bits [7:0] first. When the buffer is empty, bits [15:0] of the word (buffer bytes 0 and 1) are taken as the payload length L.
- R3: A length word with L above DEPTH-16 (2032 by default) is discarded and sets `tx_err`. The buffer stays empty.
- R4: A frame is complete when the stored byte count reaches L+16. When `crc_auto` is low, it must reach L+20 instead. The requirement is capped at DEPTH.
- R5: Threshold value 63 disables the automatic start. Any other value T is met when the byte count is at least 32*T+4. A frame starts automatically in the cycle after a data write only if the threshold is met and the frame is complete.
- R6: A one-cycle pulse on `tx_go` starts transmission whether or not the frame is complete.
- R7: The stream carries L+14 bytes, taken from buffer byte 2 onward. `m_last` marks the final byte. Data holds while `m_ready` is low. Bytes beyond L+14 in the buffer are never emitted.
- R8: With `pad_en` high and L+14 below 60, zero bytes follow the data until 60 bytes have been sent. The emitted count never exceeds DEPTH-2.
- R9: When the last byte is accepted, the buffer becomes empty and `tx_empty` is set. `ack_empty` clears it.
- R10: `ack_err` clears `tx_err` and empties the buffer. A data write in the same cycle is discarded.
- R11: While a frame is emitted, `busy` is high, data writes are not accepted and `tx_go` has no effect.
- R12: A write that would take the byte count above DEPTH is dropped.
- R13: A frame-completing write together with a `tx_go` pulse in the same cycle produces exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Data word write strobe |
| wr_data | input | 32 | Data word |
| busy | output | 1 | Frame emission in progress; writes refused |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 6 | New threshold value |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| crc_auto | input | 1 | CRC appended downstream (no CRC bytes expected in buffer) |
| tx_go | input | 1 | Forced transmission request |
| ack_empty | input | 1 | Clear the empty flag |
| ack_err | input | 1 | Clear the error flag and flush the buffer |
| tx_empty | output | 1 | A frame has been sent |
| tx_err | output | 1 | An over-long length word was rejected |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_last | output | 1 | Final byte of the frame |

## Verification
Two pairs of events can fall in the same cycle. One pair is the write that completes a frame and a forced request. The bench drives both on one edge and judges the result by the emitted byte count. It then watches that no second frame follows. The other pair is an error acknowledge and a data write. The bench drives them together, then loads a fresh frame. Any leftover length word would shift every expected byte, so the stream shows whether the write was discarded. Lengths are swept across the whole range of a 128-byte configuration, and every output byte is compared against values the bench computes.

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo #(
  parameter int DEPTH     = 2048,
  parameter int MIN_FRAME = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        busy,
  input  logic        thr_we,
  input  logic [5:0]  thr_wdata,
  input  logic        pad_en,
  input  logic        crc_auto,
  input  logic        tx_go,
  input  logic        ack_empty,
  input  logic        ack_err,
  output logic        tx_empty,
  output logic        tx_err,
  output logic [7:0]  m_data,
  output logic        m_valid,
  input  logic        m_ready,
  output logic        m_last
);
  localparam int WORDS = DEPTH / 4;
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [31:0] DEPTH_U  = 32'(DEPTH);
  localparam logic [31:0] MAXPAY_U = 32'(DEPTH - 16);
  localparam logic [31:0] MINF_U   = 32'(MIN_FRAME);
  localparam logic [31:0] HDR_U    = 32'd14;

  logic [31:0]   mem [WORDS];
  logic [CW-1:0] cnt, idx, flen, dend;
  logic [15:0]   len;
  logic [5:0]    thr;
  logic          sending;

  wire first   = (cnt == '0);
  wire len_bad = first && (32'(wr_data[15:0]) > MAXPAY_U);
  wire room    = (32'(cnt) + 32'd4) <= DEPTH_U;
  wire wr_try  = wr_valid && !sending && !ack_err;
  wire wr_ok   = wr_try && !len_bad && room;
  wire err_set = wr_try && len_bad;

  wire [CW-1:0] cnt_nx = wr_ok ? cnt + CW'(4) : cnt;
  wire [15:0]   len_nx = (wr_ok && first) ? wr_data[15:0] : len;

  logic [31:0] need, need_c, thr_bytes, flr, fl_pad, fl_cap;
  always_comb begin
    need      = 32'(len_nx) + 32'd16 + (crc_auto ? 32'd0 : 32'd4);
    need_c    = (need > DEPTH_U) ? DEPTH_U : need;
    thr_bytes = {21'b0, thr, 5'b0} + 32'd4;
    flr       = 32'(len_nx) + HDR_U;
    fl_pad    = (pad_en && flr < MINF_U) ? MINF_U : flr;
    fl_cap    = (fl_pad > DEPTH_U - 32'd2) ? DEPTH_U - 32'd2 : fl_pad;
  end

  wire complete = 32'(cnt_nx) >= need_c;
  wire thr_hit  = (thr != 6'h3F) && (32'(cnt_nx) >= thr_bytes);
  wire start    = !sending && (tx_go || (wr_ok && complete && thr_hit));
  wire done     = sending && m_ready && (idx == flen - 1'b1);

  always_ff @(posedge clk)
    if (wr_ok) mem[cnt[AW+1:2]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; len <= '0; idx <= '0; flen <= '0; dend <= '0;
      thr <= 6'h3F; sending <= 1'b0; tx_empty <= 1'b0; tx_err <= 1'b0;
    end else begin
      if (thr_we) thr <= thr_wdata;
      if (wr_ok) begin
        cnt <= cnt_nx;
        len <= len_nx;
      end
      if (start) begin
        sending <= 1'b1;
        idx     <= '0;
        flen    <= CW'(fl_cap);
        dend    <= CW'(flr);
      end else if (done) begin
        sending <= 1'b0;
        cnt     <= '0;
        len     <= '0;
      end else if (sending && m_ready) begin
        idx <= idx + 1'b1;
      end
      if (ack_err) begin
        cnt <= '0;
        len <= '0;
      end
      if (err_set)      tx_err <= 1'b1;
      else if (ack_err) tx_err <= 1'b0;
      if (done)           tx_empty <= 1'b1;
      else if (ack_empty) tx_empty <= 1'b0;
    end
  end

  wire [AW+1:0] rd_pos  = idx[AW+1:0] + 2'd2;
  wire [31:0]   rd_word = mem[rd_pos[AW+1:2]];

  assign busy    = sending;
  assign m_valid = sending;
  assign m_last  = sending && (idx == flen - 1'b1);
  assign m_data  = (sending && idx < dend) ? rd_word[{rd_pos[1:0], 3'b000} +: 8] : 8'h00;

  p_last_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_reject_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !busy && !ack_err && first && 32'(wr_data[15:0]) > MAXPAY_U)
      |=> (tx_err && cnt == '0));
  p_drain_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> (tx_empty && !m_valid && cnt == '0));
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid && !ack_err && !(m_ready && m_last)) |=> $stable(cnt));
endmodule

// File: tb/tx_frame_fifo_test.sv
module tx_frame_fifo_test;
  localparam int DEPTH  = 128;
  localparam int MAXPAY = DEPTH - 16;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, thr_we = 0, pad_en = 0, crc_auto = 1, tx_go = 0;
  logic ack_empty = 0, ack_err = 0, m_ready = 0;
  logic [31:0] wr_data = 0;
  logic [5:0] thr_wdata = 0;
  logic busy, tx_empty, tx_err, m_valid, m_last;
  logic [7:0] m_data;
  int checks = 0, fails = 0, tick = 0;

  always #2 clk = ~clk;

  tx_frame_fifo #(.DEPTH(DEPTH), .MIN_FRAME(60)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .pad_en(pad_en), .crc_auto(crc_auto),
    .tx_go(tx_go), .ack_empty(ack_empty), .ack_err(ack_err), .tx_empty(tx_empty),
    .tx_err(tx_err), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last));

  function automatic logic [7:0] patt(int l, int p);
    if (p == 0) return 8'(l);
    if (p == 1) return 8'(l >> 8);
    return 8'(p * 13 + l * 5 + 1);
  endfunction

  function automatic logic [31:0] mkword(int l, int w);
    return {patt(l, 4*w+3), patt(l, 4*w+2), patt(l, 4*w+1), patt(l, 4*w)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(logic [31:0] d, logic go);
    @(negedge clk); wr_valid = 1; wr_data = d; tx_go = go;
    @(negedge clk); wr_valid = 0; tx_go = 0;
  endtask

  task automatic set_thr(int t);
    @(negedge clk); thr_we = 1; thr_wdata = 6'(t);
    @(negedge clk); thr_we = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk); tx_go = 1;
    @(negedge clk); tx_go = 0;
  endtask

  task automatic collect(string req, int l, int xlen);
    int n = 0, bad = 0, lastpos = -1;
    for (int k = 0; k < 2000 && lastpos < 0; k++) begin
      @(negedge clk);
      tick++;
      m_ready = (tick % 3 != 2);
      if (m_valid && m_ready) begin
        if (m_data != ((n < l + 14) ? patt(l, n + 2) : 8'h00)) bad++;
        if (m_last) lastpos = n;
        n++;
      end
    end
    @(negedge clk); m_ready = 0;
    check({req, " byte count"}, n, xlen);
    check({req, " last position"}, lastpos, xlen - 1);
    check({req, " byte mismatches"}, bad, 0);
    check("R9 tx_empty after frame", int'(tx_empty), 1);
    @(negedge clk); ack_empty = 1;
    @(negedge clk); ack_empty = 0;
    check("R9 tx_empty acked", int'(tx_empty), 0);
  endtask

  function automatic int exp_len(int l, bit pad);
    int f = l + 14;
    if (pad && f < 60) f = 60;
    if (f > DEPTH - 2) f = DEPTH - 2;
    return f;
  endfunction

  task automatic auto_frame(int l, bit pad, bit crc);
    int need = l + 16 + (crc ? 0 : 4);
    int nw;
    int early = 0;
    if (need > DEPTH) need = DEPTH;
    nw = (need + 3) / 4;
    pad_en = pad; crc_auto = crc;
    for (int w = 0; w < nw; w++) begin
      write_word(mkword(l, w), 0);
      if (w < nw - 1 && busy) early++;
    end
    check("R4 no start before complete", early, 0);
    check("R4 start on completing word", int'(busy), 1);
    collect("R7 R8 R2 sweep", l, exp_len(l, pad));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int stray;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 tx_empty", int'(tx_empty), 0);
    check("R1 tx_err", int'(tx_err), 0);
    // R1: threshold resets to 63, so a complete frame must not auto-start
    for (int w = 0; w < 5; w++) write_word(mkword(4, w), 0);
    check("R1 R5 threshold reset disables auto", int'(busy), 0);
    pulse_go();
    check("R6 forced start", int'(busy), 1);
    collect("R6 forced frame", 4, 18);

    set_thr(0);
    for (int l = 0; l <= MAXPAY; l++) auto_frame(l, l[0], l[1]);

    // R3: over-long length discarded
    write_word(32'(MAXPAY + 1), 0);
    check("R3 tx_err set", int'(tx_err), 1);
    check("R3 no start", int'(busy), 0);
    auto_frame(5, 0, 1);
    @(negedge clk); ack_err = 1;
    @(negedge clk); ack_err = 0;
    check("R10 tx_err cleared", int'(tx_err), 0);

    // R10: flush with a same-cycle write
    write_word(mkword(40, 0), 0);
    write_word(mkword(40, 1), 0);
    @(negedge clk); ack_err = 1; wr_valid = 1; wr_data = 32'h0000_0007;
    @(negedge clk); ack_err = 0; wr_valid = 0;
    auto_frame(9, 1, 1);

    // R5: threshold 1 needs 36 bytes even though 16 complete the frame
    set_thr(1);
    pad_en = 1; crc_auto = 1;
    for (int w = 0; w < 8; w++) write_word(mkword(0, w), 0);
    check("R5 below threshold", int'(busy), 0);
    write_word(mkword(0, 8), 0);
    check("R5 threshold reached", int'(busy), 1);
    collect("R8 pad ignores buffer bytes", 0, 60);

    // R12: fill to DEPTH with auto disabled, extra word dropped
    set_thr(63);
    pad_en = 0; crc_auto = 0;
    for (int w = 0; w < DEPTH / 4; w++) write_word(mkword(MAXPAY, w), 0);
    write_word(32'hFFFF_FFFF, 0);
    check("R12 no auto start", int'(busy), 0);
    pulse_go();
    collect("R12 overflow dropped", MAXPAY, DEPTH - 2);

    // R11: writes and tx_go during emission are ignored
    set_thr(0);
    pad_en = 0; crc_auto = 1;
    for (int w = 0; w < 7; w++) write_word(mkword(12, w), 0);
    check("R11 busy", int'(busy), 1);
    @(negedge clk); wr_valid = 1; wr_data = 32'h0000_0003; tx_go = 1;
    @(negedge clk); wr_valid = 0; tx_go = 0;
    collect("R11 frame during blocked write", 12, 26);
    stray = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (m_valid) stray++; end
    check("R11 tx_go ignored while busy", stray, 0);
    auto_frame(21, 0, 1);

    // R13: completing write and tx_go together
    for (int w = 0; w < 11; w++) write_word(mkword(30, w), 0);
    check("R13 not started early", int'(busy), 0);
    write_word(mkword(30, 11), 1);
    collect("R13 single frame", 30, 44);
    stray = 0;
    m_ready = 1;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (m_valid) stray++; end
    m_ready = 0;
    check("R13 no second frame", stray, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule